// File: doc/BRIEF.md
# Multiplexed Segment-LCD Timing Controller

This block produces the digital timing and per-line drive codes for a segment LCD with 40 segment lines and 4 backplane lines. A host fills a 40-word by 4-bit display memory through a plain write port. Word `n` belongs to segment line `n`, and bit `k` of that word belongs to backplane `k`. The block divides its input clock into frames of exactly 24 cycles. It steps through the backplane phases of the selected multiplex ratio within each frame. It emits a 2-bit level code for every backplane and segment line, and an external analog stage turns each code into a bias voltage.

At every frame start, the memory contents are copied into a display latch. A host write in the middle of a frame therefore never disturbs the waveform that is on the glass. Also at the frame start, the multiplex ratio is sampled and the drive polarity flips, so the waveform carries no DC component. Backplane lines that the selected ratio does not use repeat the used ones, so they can be tied together for more drive strength.

For cascades, a master pulls an active-low frame marker low in the first cycle of each frame. A controller strapped as a slave restarts its frame when it samples that marker low.

Top module: `lcd_mux_driver`

## Requirements
- R1: While reset is asserted and in the first cycle after it: the frame count is 0, polarity is even, the ratio is static and the latch is all zero. So every backplane code is HIGH (2'b11), every segment code is MID (2'b01), and `syncOut_n` is 0.
- R2: A master's frame lasts exactly 24 clock cycles. `syncOut_n` is low for exactly the first cycle of each frame and high otherwise.
- R3: A write with `wrEn` high stores `wrData` into word `wrAddr` at the clock edge. Bit k of word n drives segment n during backplane phase k. Writes to addresses 40 to 63 change nothing.
- R4: The latch takes a copy of the memory only at the edge that starts a frame. A write during a frame shows on the segment codes only from the next frame.
- R5: `modeSel` is sampled at the frame-start edge: 2'b00 static (1 phase), 2'b01 1:2, 2'b10 1:3, 2'b11 1:4.
- R6: For a 1:N ratio, phase p covers frame cycles p*24/N through (p+1)*24/N-1.
- R7: The backplane whose phase is active shows HIGH (2'b11) in an even-polarity frame and LOW (2'b00) in an odd one. Every other backplane shows MID (2'b01).
- R8: A segment whose latched bit for the active phase is 1 shows the rail opposite to the active backplane: LOW in even frames, HIGH in odd frames. A segment whose bit is 0 shows MID.
- R9: The polarity flips at every frame start.
- R10: In static mode all four backplanes carry identical codes. In 1:2, backplane 2 equals backplane 0 and backplane 3 equals backplane 1. In 1:3, backplane 3 equals backplane 1.
- R11: When `isSlave` is 1 and `syncIn_n` is sampled low, the next cycle is frame cycle 0 of a new frame, with all frame-start actions. A slave never drives `syncOut_n` low.
- R12: A master ignores `syncIn_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Display memory write strobe |
| wrAddr | input | 6 | Display memory word address |
| wrData | input | 4 | Word data, bit k for backplane k |
| modeSel | input | 2 | Multiplex ratio request, sampled at frame start |
| isSlave | input | 1 | 1 = follow the external frame marker |
| syncIn_n | input | 1 | External active-low frame marker |
| syncOut_n | output | 1 | Active-low frame marker driven by a master |
| bpLvl | output | 8 | Backplane level codes, 2 bits per line, line k at [2k+1:2k] |
| segLvl | output | 80 | Segment level codes, 2 bits per line, line n at [2n+1:2n] |

## Verification
All level codes and the frame marker are decoded from registered state alone, so each output reflects the state loaded at the most recent clock edge. A memory write becomes visible only at the frame-start edge after the one at which it was stored. A ratio request or a slave marker acts at the next edge. The bench drives its inputs shortly after the falling edge and updates a behavioural model on each rising edge with the same sampled inputs. It compares every code and the marker at each falling edge, which is half a cycle after the edge that changed them. Directed checks count falling edges from a marker cycle to hit specific frame cycles.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int BP_COUNT = 4;
  localparam int PHASE_W  = 2;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_TRIPLE = 2'b10,
    MODE_QUAD   = 2'b11
  } muxMode_t;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b11
  } lvl_t;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic               frameStart;
    logic [PHASE_W-1:0] phase;
    logic               polarity;
    muxMode_t           mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl
  import lcd_mux_pkg::*;
#(
  parameter int FRAME_DIV = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  modeSel,
  input  logic        isSlave,
  input  logic        syncIn_n,
  output ctrlStrobe_t ctrl,
  output logic        syncOut_n
);

  localparam int CNT_W = $clog2(FRAME_DIV);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_DIV - 1);
  localparam logic [CNT_W-1:0] HALF   = CNT_W'(FRAME_DIV / 2);
  localparam logic [CNT_W-1:0] THIRD1 = CNT_W'(FRAME_DIV / 3);
  localparam logic [CNT_W-1:0] THIRD2 = CNT_W'(2 * FRAME_DIV / 3);
  localparam logic [CNT_W-1:0] QUART1 = CNT_W'(FRAME_DIV / 4);
  localparam logic [CNT_W-1:0] QUART2 = CNT_W'(FRAME_DIV / 2);
  localparam logic [CNT_W-1:0] QUART3 = CNT_W'(3 * FRAME_DIV / 4);

  logic [CNT_W-1:0]   frameCnt;
  logic               polarity;
  muxMode_t           modeReg;
  logic               slaveSync;
  logic               frameStart;
  logic [PHASE_W-1:0] phase;

  assign slaveSync  = isSlave && !syncIn_n;
  assign frameStart = (frameCnt == LAST) || slaveSync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameCnt <= '0;
      polarity <= 1'b0;
      modeReg  <= MODE_STATIC;
    end else if (frameStart) begin
      frameCnt <= '0;
      polarity <= ~polarity;
      modeReg  <= muxMode_t'(modeSel);
    end else begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (modeReg)
      MODE_STATIC: phase = 2'd0;
      MODE_DUAL:   phase = (frameCnt >= HALF) ? 2'd1 : 2'd0;
      MODE_TRIPLE: phase = (frameCnt >= THIRD2) ? 2'd2 :
                           (frameCnt >= THIRD1) ? 2'd1 : 2'd0;
      default:     phase = (frameCnt >= QUART3) ? 2'd3 :
                           (frameCnt >= QUART2) ? 2'd2 :
                           (frameCnt >= QUART1) ? 2'd1 : 2'd0;
    endcase
  end

  assign ctrl.frameStart = frameStart;
  assign ctrl.phase      = phase;
  assign ctrl.polarity   = polarity;
  assign ctrl.mode       = modeReg;

  assign syncOut_n = !((frameCnt == '0) && !isSlave);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frameCnt <= LAST) else $error("frame counter out of range");

  assert_sync_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !syncOut_n |=> syncOut_n) else $error("frame marker longer than one cycle");

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    slaveSync |=> frameCnt == '0) else $error("slave did not restart its frame");

  assert_master_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!isSlave && frameCnt != LAST) |=> frameCnt == $past(frameCnt) + 1'b1)
    else $error("master disturbed by external marker");

  assert_pol_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> polarity != $past(polarity)) else $error("polarity did not flip");

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> $stable(modeReg) && $stable(polarity))
    else $error("ratio or polarity changed mid-frame");

  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PHASE_W'(modeReg)) else $error("phase beyond ratio");

endmodule

// File: rtl/lcd_mux_datapath.sv
module lcd_mux_datapath
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG = 40,
  parameter int ADDR_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [BP_COUNT-1:0]     wrData,
  input  ctrlStrobe_t             ctrl,
  output logic [2*BP_COUNT-1:0]   bpLvl,
  output logic [2*NUM_SEG-1:0]    segLvl
);

  logic [NUM_SEG-1:0][BP_COUNT-1:0] ramQ;
  logic [NUM_SEG-1:0][BP_COUNT-1:0] latchQ;
  logic wrHit;

  assign wrHit = wrEn && ({1'b0, wrAddr} < (ADDR_W + 1)'(NUM_SEG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramQ   <= '0;
      latchQ <= '0;
    end else begin
      if (ctrl.frameStart) latchQ <= ramQ;
      if (wrHit) ramQ[wrAddr] <= wrData;
    end
  end

  // logical backplane feeding physical line k in a given ratio
  function automatic logic [PHASE_W-1:0] srcOf(input int k, input muxMode_t m);
    logic [PHASE_W-1:0] kk;
    kk = PHASE_W'(k);
    unique case (m)
      MODE_STATIC: return '0;
      MODE_DUAL:   return {1'b0, kk[0]};
      MODE_TRIPLE: return (kk == 2'd3) ? 2'd1 : kk;
      default:     return kk;
    endcase
  endfunction

  lvl_t activeBp, onSeg;
  assign activeBp = ctrl.polarity ? LVL_LOW : LVL_HIGH;
  assign onSeg    = ctrl.polarity ? LVL_HIGH : LVL_LOW;

  for (genvar k = 0; k < BP_COUNT; k++) begin : g_bp
    assign bpLvl[2*k +: 2] = (srcOf(k, ctrl.mode) == ctrl.phase) ? activeBp : LVL_MID;
  end

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
    assign segLvl[2*n +: 2] = latchQ[n][ctrl.phase] ? onSeg : LVL_MID;
  end

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.frameStart |=> $stable(latchQ)) else $error("latch changed mid-frame");

  assert_ignore_oob_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn || !wrHit) |=> $stable(ramQ)) else $error("memory changed without a valid write");

  assert_dup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_STATIC -> (bpLvl[1:0] == bpLvl[3:2] && bpLvl[1:0] == bpLvl[5:4]
                                   && bpLvl[1:0] == bpLvl[7:6])) &&
    (ctrl.mode == MODE_DUAL   -> (bpLvl[5:4] == bpLvl[1:0] && bpLvl[7:6] == bpLvl[3:2])) &&
    (ctrl.mode == MODE_TRIPLE -> (bpLvl[7:6] == bpLvl[3:2])))
    else $error("backplane duplication broken");

  assert_one_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mode == MODE_QUAD |-> $countones({bpLvl[0] ^ bpLvl[1], bpLvl[2] ^ bpLvl[3],
                                          bpLvl[4] ^ bpLvl[5], bpLvl[6] ^ bpLvl[7]}) == 3)
    else $error("not exactly one active backplane");

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG   = 40,
  parameter int FRAME_DIV = 24,
  parameter int ADDR_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [3:0]             wrData,
  input  logic [1:0]             modeSel,
  input  logic                   isSlave,
  input  logic                   syncIn_n,
  output logic                   syncOut_n,
  output logic [7:0]             bpLvl,
  output logic [2*NUM_SEG-1:0]   segLvl
);

  ctrlStrobe_t ctrl;

  lcd_mux_ctrl #(.FRAME_DIV(FRAME_DIV)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .isSlave(isSlave),
    .syncIn_n(syncIn_n), .ctrl(ctrl), .syncOut_n(syncOut_n)
  );

  lcd_mux_datapath #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrl(ctrl), .bpLvl(bpLvl), .segLvl(segLvl)
  );

endmodule

// File: tb/test_lcd_mux_driver.sv
`timescale 1ns/1ps
module test_lcd_mux_driver;
  localparam int NSEG = 40;
  localparam int FDIV = 24;

  logic clk = 0, rst_n = 0, wrEn = 0, isSlave = 0, syncIn_n = 1;
  logic [5:0] wrAddr = 0;
  logic [3:0] wrData = 0;
  logic [1:0] modeSel = 0;
  logic syncOut_n;
  logic [7:0] bpLvl;
  logic [2*NSEG-1:0] segLvl;

  lcd_mux_driver i_lcd_mux_driver (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modeSel(modeSel), .isSlave(isSlave), .syncIn_n(syncIn_n),
    .syncOut_n(syncOut_n), .bpLvl(bpLvl), .segLvl(segLvl)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit cmpOn = 0, done = 0;

  // behavioural reference
  int mCnt, mPol, mMode;
  logic [3:0] mRam [NSEG];
  logic [3:0] mLatch [NSEG];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = 0; mPol = 0; mMode = 0;
      for (int i = 0; i < NSEG; i++) begin mRam[i] = 0; mLatch[i] = 0; end
    end else begin
      bit start;
      start = (mCnt == FDIV - 1) || (isSlave && !syncIn_n);
      if (start) begin
        for (int i = 0; i < NSEG; i++) mLatch[i] = mRam[i];
        mMode = int'(modeSel); mPol = 1 - mPol; mCnt = 0;
      end else mCnt++;
      if (wrEn && wrAddr < NSEG) mRam[wrAddr] = wrData;
    end
  end

  function automatic int phaseOf();
    return mCnt / (FDIV / (mMode + 1));
  endfunction

  function automatic int srcOf(int k);
    case (mMode)
      0: return 0;
      1: return k % 2;
      2: return (k == 3) ? 1 : k;
      default: return k;
    endcase
  endfunction

  function automatic logic [1:0] expBp(int k);
    if (srcOf(k) == phaseOf()) return mPol ? 2'b00 : 2'b11;
    return 2'b01;
  endfunction

  function automatic logic [1:0] expSeg(int n);
    if (mLatch[n][phaseOf()]) return mPol ? 2'b11 : 2'b00;
    return 2'b01;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (cmpOn) begin
    for (int k = 0; k < 4; k++)
      check(bpLvl[2*k +: 2] == expBp(k), "R7 R10 backplane (R5 R6 R9 R11 R12)",
            int'(bpLvl[2*k +: 2]), int'(expBp(k)));
    for (int n = 0; n < NSEG; n++)
      check(segLvl[2*n +: 2] == expSeg(n), "R8 segment (R3 R4)",
            int'(segLvl[2*n +: 2]), int'(expSeg(n)));
    check(syncOut_n == !(mCnt == 0 && !isSlave), "R2 R11 frame marker",
          int'(syncOut_n), int'(!(mCnt == 0 && !isSlave)));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1 wrEn = 1; wrAddr = 6'(a); wrData = 4'(d);
    @(negedge clk); #1 wrEn = 0;
  endtask

  task automatic waitMarker();
    @(negedge clk);
    while (syncOut_n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cmpOn = 1;
    // R1: reset state visible before the first active edge
    check(bpLvl == 8'hFF, "R1 backplanes", int'(bpLvl), 'hFF);
    check(segLvl == {NSEG{2'b01}}, "R1 segments", int'(segLvl[31:0]), 'h55555555);
    check(syncOut_n == 1'b0, "R1 marker", int'(syncOut_n), 0);

    for (int i = 0; i < NSEG; i++) wr(i, (i * 7 + 3) % 16);
    cyc(30);
    // R3: out-of-range addresses must not alter any segment
    for (int a = NSEG; a < 64; a++) wr(a, 4'hF);
    cyc(30);
    // R5: each ratio requested and sampled at frame start
    for (int m = 1; m < 4; m++) begin
      modeSel = 2'(m);
      for (int i = 0; i < 10; i++) wr(i * 4, i + m);
      cyc(60);
    end

    // R6: in 1:4, phase p is active from cycle 6p
    waitMarker();
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++)
        check((bpLvl[2*k +: 2] != 2'b01) == (k == p), "R6 phase window",
              int'(bpLvl), p);
      cyc(6);
    end

    // R2: frame length 24
    begin
      int len;
      waitMarker();
      len = 0;
      do begin @(negedge clk); len++; end while (syncOut_n);
      check(len == FDIV, "R2 frame length", len, FDIV);
    end

    // R4: write mid-frame appears next frame only (static ratio)
    modeSel = 0;
    wr(0, 0);
    cyc(50);
    waitMarker();
    cyc(4);
    wr(0, 1);
    cyc(17);
    check(segLvl[1:0] == 2'b01, "R4 held until frame end", int'(segLvl[1:0]), 1);
    cyc(1);
    check(segLvl[1:0] != 2'b01, "R4 shown from next frame", int'(segLvl[1:0]), 0);

    // R9: polarity alternates between frames
    begin
      logic [1:0] first;
      first = bpLvl[1:0];
      cyc(FDIV);
      check(bpLvl[1:0] != first && bpLvl[1:0] != 2'b01, "R9 polarity flip",
            int'(bpLvl[1:0]), int'(~first));
    end

    // R12: a master ignores an external marker
    begin
      int len;
      modeSel = 3;
      cyc(30);
      waitMarker();
      cyc(5);
      #1 syncIn_n = 0;
      @(negedge clk); #1 syncIn_n = 1;
      len = 6;
      do begin @(negedge clk); len++; end while (syncOut_n);
      check(len == FDIV, "R12 master period unchanged", len, FDIV);
    end

    // R11: slave restarts its frame on the marker
    #1 isSlave = 1;
    cyc(7);
    #1 syncIn_n = 0;
    @(negedge clk);
    check(bpLvl[1:0] != 2'b01 && bpLvl[7:2] == 6'b010101, "R11 slave restart",
          int'(bpLvl), 0);
    check(syncOut_n == 1'b1, "R11 slave silent", int'(syncOut_n), 1);
    #1 syncIn_n = 1;
    cyc(40);

    done = 1;
    cmpOn = 0;
    summary();
    $finish;
  end
endmodule